// File: doc/BRIEF.md
# Entropy Holding Register with Block Repetition Test

This block gathers debiased entropy bits, one per strobe, into a 192-bit holding register. Bits are taken only while the source-enable input is high. Software polls or waits for an interrupt. Once the valid status shows that all 192 bits are in place, it reads them back as six 32-bit words. During the fill, a continuous repetition test checks each 16-bit block as it completes against the block completed just before it. An equal pair is treated as a stuck or degraded source. It raises a sticky error, throws away the partial fill and starts collecting again from bit 0. A debug input turns the test off.

The control side is a plain register port with a write strobe, a word address, two write-data bits and a combinational read-data bus. A two-state controller governs the fill:

- **FILL** accepts bits and has three ways out:
  - *fill_done* moves to **HELD** when the last bit arrives with no test failure.
  - *rep_restart* stays in **FILL** with the counter at zero after a failure.
  - *cnt_restart* stays in **FILL** with the counter at zero on an accepted counter-reset command.
- **HELD** presents the data and accepts no bits. It returns to **FILL** through *valid_release* (a write-one-to-clear of the valid status) or *cnt_restart*.

Top module: `entropy_hold_reg`

## Requirements
- R1: The valid status (status bit 0) rises on the clock edge that accepts the 192nd bit since collection last started, and is low after 191 bits.
- R2: The i-th accepted bit (first bit is i = 0) lands at bit i of the holding register. Word address w (0 to 5) reads bits 32w+31..32w. Data words read as zero while valid is low.
- R3: When the 16 bits at positions 16k..16k+15 complete and equal the block completed immediately before (in this fill or the previous one), error status bit 1 is set. The error stays set until cleared. The partial fill is discarded and collection restarts at bit 0, with valid remaining low.
- R4: While dbg_bypass is high, equal consecutive blocks raise no error and are stored like any other block.
- R5: A write to address 0xB clears the bit counter and the valid status when src_en is low. When src_en is high the write is ignored and valid, if set, stays set.
- R6: Address 0x8 reads the status: bit 0 is valid and bit 1 is error. Writing 1 to bit 0 or bit 1 at address 0xA clears that status bit. Clearing valid restarts collection at bit 0.
- R7: Address 0x9 holds a two-bit mask in the same bit positions as the status, reset to 2'b11 (both masked). irq is high exactly when some status bit is set and its mask bit is 0.
- R8: A bit is accepted only on a cycle where bit_vld and src_en are both high and valid is low. Bits offered in HELD or with src_en low change nothing.
- R9: busy is high exactly when src_en is high and valid is low.
- R10: After reset the status reads 0, the mask reads 3, irq is low and data words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 1 | Entropy source enable; bits are taken only while high |
| dbg_bypass | input | 1 | Debug: disables the block repetition test |
| bit_vld | input | 1 | Strobe marking a debiased bit on bit_in |
| bit_in | input | 1 | Debiased entropy bit |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address for reads and writes |
| wr_bits | input | 2 | Write data (mask or clear bits) |
| rdata | output | 32 | Combinational read data for addr |
| irq | output | 1 | OR of unmasked status bits |
| busy | output | 1 | Collection in progress |

## Verification
The bench builds the block with its default parameters: a 192-bit holding register, 16-bit test blocks and 32-bit words. With these values the word-to-block mapping is exact (two blocks per word), and twelve blocks complete a fill. A repeated block can therefore be injected at the first, a middle or the last block position, which exercises a restart just before completion. The bench produces blocks from a sequence that never repeats by itself, so every error it sees comes from a deliberate injection. That also lets it check that the test reference carries over across the fills, the counter resets and the ignored bits in between.

// File: rtl/ehr_pkg.sv
package ehr_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_HELD = 1'b1
    } fill_state_t;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned STAT_W = 2;

    // status / mask / clear bit positions (shared by all three registers)
    localparam int unsigned STAT_VALID = 0;
    localparam int unsigned STAT_ERR   = 1;

    // control word addresses; data words occupy 0 .. NWORDS-1
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'h8;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 4'h9;
    localparam logic [ADDR_W-1:0] ADDR_CLEAR  = 4'hA;
    localparam logic [ADDR_W-1:0] ADDR_CNTRST = 4'hB;

endpackage

// File: rtl/ehr_rep_test.sv
module ehr_rep_test #(
    parameter int unsigned BLK_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    input  logic blk_done,
    input  logic bypass,
    output logic rep_fail
);

    logic [BLK_W-1:0] cur_q;
    logic [BLK_W-1:0] cur_next;
    logic [BLK_W-1:0] ref_q;
    logic             ref_vld_q;

    // newest bit enters at the top so the first bit of a block ends at bit 0
    assign cur_next = {bit_in, cur_q[BLK_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (shift_en) begin
            cur_q <= cur_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q     <= '0;
            ref_vld_q <= 1'b0;
        end else if (shift_en && blk_done) begin
            ref_q     <= cur_next;
            ref_vld_q <= 1'b1;
        end
    end

    assign rep_fail = shift_en && blk_done && ref_vld_q && !bypass
                      && (cur_next == ref_q);

endmodule

// File: rtl/ehr_collector.sv
module ehr_collector
    import ehr_pkg::*;
#(
    parameter int unsigned HOLD_W = 192,
    parameter int unsigned BLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              src_en,
    input  logic              rep_fail,
    input  logic              valid_clr,
    input  logic              cnt_rst_req,
    output logic              accept,
    output logic              blk_done,
    output logic              last_bit,
    output logic              valid,
    output logic [$clog2(HOLD_W)-1:0] bit_cnt,
    output logic [HOLD_W-1:0] hold
);

    localparam int unsigned CNT_W   = $clog2(HOLD_W);
    localparam int unsigned BLK_LOG = $clog2(BLK_W);

    fill_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [HOLD_W-1:0] hold_q;
    logic             cnt_rst;
    logic             cnt_zero;

    assign cnt_rst  = cnt_rst_req && !src_en;
    assign accept   = (state_q == ST_FILL) && bit_vld && src_en;
    assign blk_done = (cnt_q[BLK_LOG-1:0] == BLK_LOG'(BLK_W-1));
    assign last_bit = (cnt_q == CNT_W'(HOLD_W-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (cnt_rst)                                state_d = ST_FILL;
                else if (accept && last_bit && !rep_fail)   state_d = ST_HELD;
            end
            ST_HELD: begin
                if (valid_clr || cnt_rst)                   state_d = ST_FILL;
            end
            default:                                        state_d = ST_FILL;
        endcase
    end

    // bit counter clears on every restart and on completion
    always_comb begin
        cnt_zero = cnt_rst || rep_fail || (state_q == ST_HELD && valid_clr)
                   || (accept && last_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_zero) cnt_q <= '0;
        else if (accept)   cnt_q <= cnt_q + 1'b1;
    end

    // holding register: each bit has its own write enable
    generate
        for (genvar i = 0; i < HOLD_W; i++) begin : g_hold
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    hold_q[i] <= 1'b0;
                else if (accept && cnt_q == CNT_W'(i))
                    hold_q[i] <= bit_in;
            end
        end
    endgenerate

    // outputs
    always_comb begin
        valid   = (state_q == ST_HELD);
        bit_cnt = cnt_q;
        hold    = hold_q;
    end

endmodule

// File: rtl/ehr_regs.sv
module ehr_regs
    import ehr_pkg::*;
#(
    parameter int unsigned HOLD_W = 192,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [STAT_W-1:0] wr_bits,
    input  logic              valid,
    input  logic              rep_fail,
    input  logic [HOLD_W-1:0] hold,
    output logic              valid_clr,
    output logic              cnt_rst_req,
    output logic              err,
    output logic [STAT_W-1:0] mask,
    output logic              irq,
    output logic [WORD_W-1:0] rdata
);

    localparam int unsigned NWORDS = HOLD_W / WORD_W;

    logic [STAT_W-1:0] mask_q;
    logic              err_q;
    logic [STAT_W-1:0] status;
    logic              clr_wr;
    logic [WORD_W-1:0] words [NWORDS];

    assign clr_wr      = wr_en && (addr == ADDR_CLEAR);
    assign valid_clr   = clr_wr && wr_bits[STAT_VALID];
    assign cnt_rst_req = wr_en && (addr == ADDR_CNTRST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            mask_q <= '1;
        else if (wr_en && addr == ADDR_MASK)   mask_q <= wr_bits;
    end

    // sticky error; a new failure wins over a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            err_q <= 1'b0;
        else if (rep_fail)                     err_q <= 1'b1;
        else if (clr_wr && wr_bits[STAT_ERR])  err_q <= 1'b0;
    end

    always_comb begin
        status             = '0;
        status[STAT_VALID] = valid;
        status[STAT_ERR]   = err_q;
    end

    generate
        for (genvar w = 0; w < NWORDS; w++) begin : g_word
            assign words[w] = hold[w*WORD_W +: WORD_W];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (addr == ADDR_STATUS) begin
            rdata[STAT_W-1:0] = status;
        end else if (addr == ADDR_MASK) begin
            rdata[STAT_W-1:0] = mask_q;
        end else if (valid) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (addr == ADDR_W'(w)) rdata = words[w];
            end
        end
    end

    assign irq  = |(status & ~mask_q);
    assign err  = err_q;
    assign mask = mask_q;

endmodule

// File: rtl/entropy_hold_reg.sv
module entropy_hold_reg
    import ehr_pkg::*;
#(
    parameter int unsigned HOLD_W = 192,
    parameter int unsigned BLK_W  = 16,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_en,
    input  logic              dbg_bypass,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [STAT_W-1:0] wr_bits,
    output logic [WORD_W-1:0] rdata,
    output logic              irq,
    output logic              busy
);

    localparam int unsigned CNT_W = $clog2(HOLD_W);

    logic              accept;
    logic              blk_done;
    logic              last_bit;
    logic              rep_fail;
    logic              valid_st;
    logic              valid_clr;
    logic              cnt_rst_req;
    logic              err_st;
    logic [STAT_W-1:0] mask;
    logic [CNT_W-1:0]  bit_cnt;
    logic [HOLD_W-1:0] hold;

    ehr_collector #(.HOLD_W(HOLD_W), .BLK_W(BLK_W)) u_collect (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_vld     (bit_vld),
        .bit_in      (bit_in),
        .src_en      (src_en),
        .rep_fail    (rep_fail),
        .valid_clr   (valid_clr),
        .cnt_rst_req (cnt_rst_req),
        .accept      (accept),
        .blk_done    (blk_done),
        .last_bit    (last_bit),
        .valid       (valid_st),
        .bit_cnt     (bit_cnt),
        .hold        (hold)
    );

    ehr_rep_test #(.BLK_W(BLK_W)) u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .bit_in   (bit_in),
        .blk_done (blk_done),
        .bypass   (dbg_bypass),
        .rep_fail (rep_fail)
    );

    ehr_regs #(.HOLD_W(HOLD_W), .WORD_W(WORD_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wr_bits     (wr_bits),
        .valid       (valid_st),
        .rep_fail    (rep_fail),
        .hold        (hold),
        .valid_clr   (valid_clr),
        .cnt_rst_req (cnt_rst_req),
        .err         (err_st),
        .mask        (mask),
        .irq         (irq),
        .rdata       (rdata)
    );

    assign busy = src_en && !valid_st;

endmodule

// File: rtl/entropy_hold_reg_chk.sv
module entropy_hold_reg_chk
    import ehr_pkg::*;
#(
    parameter int unsigned HOLD_W = 192
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [STAT_W-1:0] wr_bits,
    input logic              accept,
    input logic              last_bit,
    input logic              rep_fail,
    input logic              valid_st,
    input logic              err_st,
    input logic [STAT_W-1:0] mask,
    input logic              irq,
    input logic              busy,
    input logic [$clog2(HOLD_W)-1:0] bit_cnt,
    input logic [HOLD_W-1:0] hold
);

    a_r1_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        accept && last_bit && !rep_fail |=> valid_st);

    a_r3_fail_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        rep_fail |=> (bit_cnt == '0) && !valid_st);

    a_r5_cnt_reset_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == ADDR_CNTRST && src_en && valid_st |=> valid_st);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_st && !(wr_en && addr == ADDR_CLEAR && wr_bits[STAT_ERR]) |=> err_st);

    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq);

    a_r8_held_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        valid_st |=> $stable(hold));

    a_r9_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_st || !src_en) |-> !busy);

endmodule

bind entropy_hold_reg entropy_hold_reg_chk #(.HOLD_W(HOLD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_en   (src_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_bits  (wr_bits),
    .accept   (accept),
    .last_bit (last_bit),
    .rep_fail (rep_fail),
    .valid_st (valid_st),
    .err_st   (err_st),
    .mask     (mask),
    .irq      (irq),
    .busy     (busy),
    .bit_cnt  (bit_cnt),
    .hold     (hold)
);

// File: tb/entropy_hold_reg_bench.sv
module entropy_hold_reg_bench;

    localparam logic [3:0] A_STATUS = 4'h8;
    localparam logic [3:0] A_MASK   = 4'h9;
    localparam logic [3:0] A_CLEAR  = 4'hA;
    localparam logic [3:0] A_CNTRST = 4'hB;
    localparam int NBLK = 12;
    localparam int NVEC = 5;

    // vector: {repeat position (F = none), bypass, mask[1:0]}
    localparam logic [6:0] VEC [NVEC] = '{
        {4'hF, 1'b0, 2'b11},
        {4'h5, 1'b0, 2'b00},
        {4'h3, 1'b1, 2'b10},
        {4'hB, 1'b0, 2'b01},
        {4'h1, 1'b0, 2'b11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_en = 1'b0;
    logic        dbg_bypass = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [1:0]  wr_bits = 2'b00;
    logic [31:0] rdata;
    logic        irq;
    logic        busy;

    int          n_chk = 0;
    int          n_bad = 0;
    int          g = 0;
    logic [15:0] last_blk = 16'h0;
    logic [15:0] exp_blk [NBLK];
    int          idx = 0;
    logic [31:0] v;

    always #2 clk = ~clk;

    entropy_hold_reg u_entropy_hold_reg (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .dbg_bypass(dbg_bypass),
        .bit_vld(bit_vld), .bit_in(bit_in), .wr_en(wr_en), .addr(addr),
        .wr_bits(wr_bits), .rdata(rdata), .irq(irq), .busy(busy)
    );

    function automatic logic [15:0] gen(input int n);
        logic [31:0] p;
        p = n * 32'h3B1D;
        return 16'hA5C3 ^ p[15:0];
    endfunction

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_bits = d;
        @(negedge clk);
        wr_en = 1'b0; wr_bits = 2'b00;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] r);
        @(negedge clk);
        addr = a;
        #1 r = rdata;
    endtask

    task automatic send_range(input logic [15:0] b, input int lo, input int hi);
        for (int i = lo; i <= hi; i++) begin
            @(negedge clk);
            bit_vld = 1'b1; bit_in = b[i];
        end
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_new(output logic [15:0] b);
        b = gen(g); g++; last_blk = b;
        send_range(b, 0, 15);
    endtask

    task automatic fill_fresh;
        logic [15:0] b;
        idx = 0;
        while (idx < NBLK) begin
            send_new(b);
            exp_blk[idx] = b; idx++;
        end
    endtask

    task automatic check_words(input string req);
        logic [31:0] r;
        for (int w = 0; w < NBLK/2; w++) begin
            rd(4'(w), r);
            chk(req, r, {exp_blk[2*w+1], exp_blk[2*w]});
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [15:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        rd(A_STATUS, v); chk("R10 status", v, 0);
        rd(A_MASK, v);   chk("R10 mask", v, 3);
        rd(4'h0, v);     chk("R10 word0", v, 0);
        chk("R10 irq", {31'b0, irq}, 0);
        chk("R9 busy off", {31'b0, busy}, 0);

        src_en = 1'b1;
        #1 chk("R9 busy on", {31'b0, busy}, 1);

        // table of vectors: R3 R4 R7 R2
        for (int e = 0; e < NVEC; e++) begin
            logic [3:0] rep;
            logic       byp;
            logic [1:0] msk;
            logic       exp_err;
            int         k;
            {rep, byp, msk} = VEC[e];
            wr(A_MASK, msk);
            dbg_bypass = byp;
            exp_err = 1'b0;
            idx = 0; k = 0;
            while (idx < NBLK) begin
                if (k == int'(rep)) begin
                    b = last_blk;
                    send_range(b, 0, 15);
                    if (byp) begin exp_blk[idx] = b; idx++; end
                    else begin exp_err = 1'b1; idx = 0; end
                end else begin
                    send_new(b);
                    exp_blk[idx] = b; idx++;
                end
                k++;
            end
            rd(A_STATUS, v);
            chk("R3/R4 status after fill", v, {30'b0, exp_err, 1'b1});
            chk("R7 irq", {31'b0, irq}, {31'b0, |({exp_err, 1'b1} & ~msk)});
            chk("R9 busy held", {31'b0, busy}, 0);
            check_words("R2 words");
            wr(A_CLEAR, 2'b11);
            rd(A_STATUS, v); chk("R6 clear both", v, 0);
        end
        dbg_bypass = 1'b0;
        wr(A_MASK, 2'b11);

        // R8/R1: bits while disabled ignored; exact 192-bit boundary
        src_en = 1'b0;
        b = gen(g); g++; last_blk = b;
        send_range(b, 0, 15);
        src_en = 1'b1;
        idx = 0;
        for (int i = 0; i < NBLK - 1; i++) begin
            send_new(b); exp_blk[idx] = b; idx++;
        end
        b = gen(g); g++; last_blk = b; exp_blk[idx] = b;
        send_range(b, 0, 14);
        rd(A_STATUS, v); chk("R1 not valid at 191", v, 0);
        rd(4'h5, v);     chk("R2 zero while filling", v, 0);
        send_range(b, 15, 15);
        rd(A_STATUS, v); chk("R1 valid at 192", v, 1);
        check_words("R8 disabled bits ignored");

        // R8: bits offered while held change nothing
        b = gen(g); g++;
        send_range(b, 0, 15);
        check_words("R8 held frozen");

        // R5: counter reset ignored while enabled, honoured while disabled
        wr(A_CNTRST, 2'b00);
        rd(A_STATUS, v); chk("R5 ignored when enabled", v, 1);
        src_en = 1'b0;
        wr(A_CNTRST, 2'b00);
        rd(A_STATUS, v); chk("R5 clears valid", v, 0);

        // R5: mid-fill counter reset discards the partial fill
        src_en = 1'b1;
        for (int i = 0; i < 6; i++) send_new(b);
        src_en = 1'b0;
        wr(A_CNTRST, 2'b00);
        src_en = 1'b1;
        fill_fresh();
        rd(A_STATUS, v); chk("R5 refill valid", v, 1);
        check_words("R5 refill data");
        wr(A_CLEAR, 2'b01);
        rd(A_STATUS, v); chk("R6 clear valid only", v, 0);

        // R3/R6: error is sticky and cleared by write-one
        send_new(b);
        send_range(last_blk, 0, 15);
        rd(A_STATUS, v); chk("R3 error set", v, 2);
        chk("R7 masked irq", {31'b0, irq}, 0);
        wr(A_CLEAR, 2'b01);
        rd(A_STATUS, v); chk("R6 err survives valid clear", v, 2);
        wr(A_CLEAR, 2'b10);
        rd(A_STATUS, v); chk("R6 err cleared", v, 0);

        report();
        $finish;
    end

endmodule